// File: doc/BRIEF.md
# Word Shifter with Carry Generation

This block is the shift and rotate datapath of a 32-bit integer unit. In one operation it does one of three jobs. It can shift a word left or right, either logically or arithmetically. It can rotate a word left and keep only the bits under a contiguous mask. It can rotate a word left and merge the bits under the mask into an older destination value. The arithmetic right shifts also produce a carry flag, which tells software whether a negative value lost any set bits on the way out. Software uses this flag to round a signed division by a power of two towards zero.

The shift amount is a 6-bit operand. For the register-sourced shifts, bit 5 of the amount is significant: when it is set, the shift saturates. For the immediate arithmetic shift and for the rotates, only the low 5 bits are used. The mask is given as a begin position and an end position in big-endian bit numbering (position 0 is the most significant bit). When begin is greater than end, the mask wraps around. The operation is selected by a 3-bit code. The result, the carry and a carry-write flag are registered and appear one clock after the request.

Top module: `shw_word_shifter`

## Requirements
- R1: With op code 0 (shift left), the result is the source shifted left by amt[4:0] with zeros filled in; when amt[5] is 1 the result is zero.
- R2: With op code 1 (logical shift right), the result is the source shifted right by amt[4:0] with zeros filled in; when amt[5] is 1 the result is zero.
- R3: With op code 2 (arithmetic shift right by register) and amt[5] = 0, the result is the source shifted right by amt[4:0] with copies of bit 31 filled in. The carry is 1 exactly when bit 31 of the source is 1 and at least one bit shifted out is 1.
- R4: With op code 2 and amt[5] = 1, the result is all ones for a negative source and zero otherwise. The carry is 1 only when the source is negative and bits 30:0 of the source are not all zero.
- R5: An arithmetic shift by zero (op code 2 with amt = 0, or op code 3 with amt[4:0] = 0) returns the source unchanged and clears the carry.
- R6: With op code 3 (arithmetic shift right by immediate), amt[5] is ignored. The result and carry follow R3 for a shift by amt[4:0].
- R7: The mask has a 1 at big-endian position p when mb <= p <= me, for mb <= me. For mb > me it has a 1 when p >= mb or p <= me. Big-endian position p is result bit 31-p.
- R8: With op code 4 (rotate and mask), the result is the source rotated left by amt[4:0], ANDed with the mask of R7.
- R9: With op code 5 (rotate and insert), the result takes the rotated source where the mask is 1 and the old destination value where the mask is 0.
- R10: carry_wr is 1 only for op codes 2 and 3. For op codes 0, 1, 4, 5 and the unused codes 6 and 7, carry_wr and carry_out are 0, and codes 6 and 7 give a zero result.
- R11: A request accepted with in_valid appears on out_valid, result and carry_out after exactly one clock. While rst_n is low, all outputs are cleared at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation code |
| src | input | 32 | Source word |
| amt | input | 6 | Shift or rotate amount |
| mb | input | 5 | Mask begin, big-endian position |
| me | input | 5 | Mask end, big-endian position |
| old | input | 32 | Old destination value for the insert form |
| out_valid | output | 1 | Result present |
| result | output | 32 | Shift or rotate result |
| carry_out | output | 1 | Carry flag value |
| carry_wr | output | 1 | The carry flag is to be written |

## Verification
The hardest cases to reach are the boundaries of the carry rule. These include a negative source whose shifted-out bits are all zero, such as the minimum negative value shifted by any amount. They also include a saturated arithmetic shift of a negative value that has only the sign bit set, and a positive source with set bits shifted out. Random stimulus seldom produces these cases, so the bench drives them as directed vectors. These include a saturated amount of 32 and of 63, and an immediate shift with amt[5] set to show that the bit is ignored. The bench also covers masks that wrap, single-bit masks and the full mask, and then runs a random sweep through the scoreboard.

// File: rtl/shw_pkg.sv
// Package: shared operation codes for the word shifter.
// Assumes: a 3-bit operation field; codes 6 and 7 are unused.
package shw_pkg;
    typedef enum logic [2:0] {
        SHW_SLL  = 3'd0,
        SHW_SRL  = 3'd1,
        SHW_SRA  = 3'd2,
        SHW_SRAI = 3'd3,
        SHW_RLM  = 3'd4,
        SHW_RLMI = 3'd5,
        SHW_RSV6 = 3'd6,
        SHW_RSV7 = 3'd7
    } shw_op_e;
endpackage

// File: rtl/shw_shift_core.sv
// Module: combinational shifts and the arithmetic-shift carry.
// Assumes: W is a power of two; amt[SHW] is the saturation bit for the
// register forms and is ignored by the immediate arithmetic form.
module shw_shift_core
    import shw_pkg::*;
#(
    parameter int W   = 32,
    localparam int SHW = $clog2(W)
) (
    input  shw_op_e      op,
    input  logic [W-1:0] src,
    input  logic [SHW:0] amt,
    output logic [W-1:0] shf_res,
    output logic         shf_carry
);
    logic [SHW-1:0] n;
    logic           sat;
    logic [W-1:0]   lost_mask;
    logic           neg;

    assign n         = amt[SHW-1:0];
    assign neg       = src[W-1];
    assign lost_mask = ~({W{1'b1}} << n);

    // Purpose: only the register forms honour the saturation bit.
    always_comb begin
        sat = amt[SHW] && (op != SHW_SRAI);
    end

    // Purpose: select the shifted value and the carry for this operation.
    always_comb begin
        shf_res   = '0;
        shf_carry = 1'b0;
        unique case (op)
            SHW_SLL: shf_res = sat ? '0 : (src << n);
            SHW_SRL: shf_res = sat ? '0 : (src >> n);
            SHW_SRA, SHW_SRAI: begin
                if (sat) begin
                    shf_res   = {W{neg}};
                    shf_carry = neg && (|src[W-2:0]);
                end else begin
                    shf_res   = $unsigned($signed(src) >>> n);
                    shf_carry = neg && (|(src & lost_mask));
                end
            end
            default: begin
                shf_res   = '0;
                shf_carry = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/shw_mask_gen.sv
// Module: builds a contiguous (possibly wrapping) mask from big-endian
// begin/end positions. Position p maps to little-endian bit W-1-p.
// Assumes: mb and me are in range 0..W-1.
module shw_mask_gen #(
    parameter int W   = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [SHW-1:0] mb,
    input  logic [SHW-1:0] me,
    output logic [W-1:0]   mask
);
    logic wrap;
    assign wrap = (mb > me);

    for (genvar j = 0; j < W; j++) begin : g_bit
        localparam logic [SHW-1:0] POS = SHW'(W - 1 - j);
        logic ge_b;
        logic le_e;
        // Purpose: decide membership of this bit position in the mask.
        always_comb begin
            ge_b    = (POS >= mb);
            le_e    = (POS <= me);
            mask[j] = wrap ? (ge_b || le_e) : (ge_b && le_e);
        end
    end
endmodule

// File: rtl/shw_rotmask.sv
// Module: rotate left, then mask, optionally merging an old value.
// Assumes: the mask comes from shw_mask_gen; n is taken modulo W.
module shw_rotmask #(
    parameter int W   = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   src,
    input  logic [SHW-1:0] n,
    input  logic [W-1:0]   mask,
    input  logic [W-1:0]   old,
    input  logic           insert,
    output logic [W-1:0]   rot_res
);
    logic [2*W-1:0] dbl;
    logic [W-1:0]   rot;

    // Purpose: rotate by shifting a doubled copy and taking the top half.
    always_comb begin
        dbl = {src, src} << n;
        rot = dbl[2*W-1:W];
    end

    // Purpose: apply the mask and, for the insert form, merge the old value.
    always_comb begin
        rot_res = (rot & mask) | (insert ? (old & ~mask) : '0);
    end
endmodule

// File: rtl/shw_word_shifter.sv
// Module: top of the word shifter; selects the shift or rotate path and
// registers result, carry and carry-write flag for one cycle.
// Assumes: synchronous active-low reset; one request per cycle at most.
module shw_word_shifter
    import shw_pkg::*;
#(
    parameter int W   = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [2:0]     op,
    input  logic [W-1:0]   src,
    input  logic [SHW:0]   amt,
    input  logic [SHW-1:0] mb,
    input  logic [SHW-1:0] me,
    input  logic [W-1:0]   old,
    output logic           out_valid,
    output logic [W-1:0]   result,
    output logic           carry_out,
    output logic           carry_wr
);
    shw_op_e      op_e;
    logic [W-1:0] shf_res;
    logic         shf_carry;
    logic [W-1:0] mask_w;
    logic [W-1:0] rot_res;
    logic [W-1:0] nxt_res;
    logic         nxt_carry;
    logic         nxt_cwr;
    logic         is_rot;
    logic         is_sra;

    assign op_e = shw_op_e'(op);

    shw_shift_core #(.W(W)) u_shift (
        .op       (op_e),
        .src      (src),
        .amt      (amt),
        .shf_res  (shf_res),
        .shf_carry(shf_carry)
    );

    shw_mask_gen #(.W(W)) u_mask (
        .mb  (mb),
        .me  (me),
        .mask(mask_w)
    );

    shw_rotmask #(.W(W)) u_rot (
        .src    (src),
        .n      (amt[SHW-1:0]),
        .mask   (mask_w),
        .old    (old),
        .insert (op_e == SHW_RLMI),
        .rot_res(rot_res)
    );

    // Purpose: pick the path output and decide whether the carry is written.
    always_comb begin
        is_rot    = (op_e == SHW_RLM) || (op_e == SHW_RLMI);
        is_sra    = (op_e == SHW_SRA) || (op_e == SHW_SRAI);
        nxt_res   = is_rot ? rot_res : shf_res;
        nxt_carry = is_sra && shf_carry;
        nxt_cwr   = is_sra;
    end

    // Purpose: output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            carry_out <= 1'b0;
            carry_wr  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= nxt_res;
                carry_out <= nxt_carry;
                carry_wr  <= nxt_cwr;
            end
        end
    end

    // R11: a request shows up on out_valid one cycle later
    a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10: logical shifts and rotates never write or set the carry
    a_r10_no_carry_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(op == 3'd2 || op == 3'd3)) |=> (!carry_wr && !carry_out));

    // R3/R4: a carry can only come from a negative source
    a_r3_carry_needs_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 3'd2 || op == 3'd3)) |=> (!carry_out || $past(src[W-1])));

    // R1/R2: saturated logical shifts give zero
    a_r1_sat_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 3'd0 || op == 3'd1) && amt[SHW]) |=> (result == '0));

    // R5: arithmetic shift by zero passes the source and clears the carry
    a_r5_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd2 && amt == '0) |=> (result == $past(src) && !carry_out));

    // R8: rotate-and-mask leaves nothing outside the mask
    a_r8_outside_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd4) |=> ((result & ~$past(mask_w)) == '0));

    // R9: insert form keeps the old value outside the mask
    a_r9_outside_mask_old: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd5) |=> (((result ^ $past(old)) & ~$past(mask_w)) == '0));
endmodule

// File: tb/shw_word_shifter_tb.sv
module shw_word_shifter_tb;
    localparam int W = 32;

    typedef struct {
        logic [31:0] res;
        logic        cy;
        logic        cwr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] src = '0;
    logic [5:0]  amt = '0;
    logic [4:0]  mb = '0;
    logic [4:0]  me = '0;
    logic [31:0] old = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        carry_out;
    logic        carry_wr;

    int total = 0;
    int bad = 0;
    bit done = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    shw_word_shifter #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .src(src),
        .amt(amt), .mb(mb), .me(me), .old(old), .out_valid(out_valid),
        .result(result), .carry_out(carry_out), .carry_wr(carry_wr)
    );

    function automatic logic [31:0] ref_mask(input logic [4:0] b, input logic [4:0] e);
        logic [31:0] m = '0;
        for (int p = 0; p < 32; p++) begin
            bit inside_rng;
            if (b <= e) inside_rng = (p >= b) && (p <= e);
            else        inside_rng = !((p > e) && (p < b));
            m[31 - p] = inside_rng;
        end
        return m;
    endfunction

    function automatic exp_t model(input logic [2:0] o, input logic [31:0] s,
                                   input logic [5:0] a, input logic [4:0] b,
                                   input logic [4:0] e, input logic [31:0] od);
        exp_t x;
        int   k;
        logic [31:0] r;
        logic [31:0] m;
        x.res = '0; x.cy = 0; x.cwr = 0;
        k = int'(a[4:0]);
        case (o)
            3'd0: begin x.tag = "R1"; x.res = a[5] ? 32'd0 : s << k; end
            3'd1: begin x.tag = "R2"; x.res = a[5] ? 32'd0 : s >> k; end
            3'd2, 3'd3: begin
                x.cwr = 1;
                if (o == 3'd2 && a[5]) begin
                    x.tag = "R4";
                    x.res = s[31] ? 32'hFFFF_FFFF : 32'd0;
                    x.cy  = s[31] && (s[30:0] != 0);
                end else begin
                    x.tag = (k == 0) ? "R5" : ((o == 3'd3) ? "R6" : "R3");
                    r = s;
                    for (int i = 0; i < k; i++) begin
                        if (r[0] && s[31]) x.cy = 1;
                        r = {s[31], r[31:1]};
                    end
                    x.res = r;
                end
            end
            3'd4, 3'd5: begin
                x.tag = (o == 3'd4) ? "R8" : "R9";
                r = s;
                for (int i = 0; i < k; i++) r = {r[30:0], r[31]};
                m = ref_mask(b, e);
                x.res = (r & m) | ((o == 3'd5) ? (od & ~m) : 32'd0);
            end
            default: x.tag = "R10";
        endcase
        return x;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic drive(input logic [2:0] o, input logic [31:0] s, input logic [5:0] a,
                         input logic [4:0] b, input logic [4:0] e, input logic [31:0] od);
        @(negedge clk);
        in_valid = 1; op = o; src = s; amt = a; mb = b; me = e; old = od;
        sb.push_back(model(o, s, a, b, e, od));
    endtask

    // Monitor: pop one expected item per valid output and compare.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                exp_t x;
                if (sb.size() == 0) begin
                    check("R11", "unexpected out_valid", 32'd1, 32'd0);
                end else begin
                    x = sb.pop_front();
                    check(x.tag, "result", result, x.res);
                    check(x.tag, "carry_out", {31'd0, carry_out}, {31'd0, x.cy});
                    check("R10", "carry_wr", {31'd0, carry_wr}, {31'd0, x.cwr});
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs cleared in reset
        check("R11", "reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R11", "reset result", result, 32'd0);
        check("R11", "reset carry", {31'd0, carry_out}, 32'd0);
        rst_n = 1;
        // R1
        drive(3'd0, 32'h8000_0F01, 6'd4, 0, 0, 0);
        drive(3'd0, 32'h0000_0003, 6'd31, 0, 0, 0);
        drive(3'd0, 32'hFFFF_FFFF, 6'd32, 0, 0, 0);
        drive(3'd0, 32'hFFFF_FFFF, 6'd63, 0, 0, 0);
        // R2
        drive(3'd1, 32'h8000_00F0, 6'd4, 0, 0, 0);
        drive(3'd1, 32'hFFFF_FFFF, 6'd31, 0, 0, 0);
        drive(3'd1, 32'hFFFF_FFFF, 6'd40, 0, 0, 0);
        // R3: negative, lost ones -> carry; negative, lost zeros -> none; positive
        drive(3'd2, 32'hFFFF_FFF1, 6'd4, 0, 0, 0);
        drive(3'd2, 32'h8000_0000, 6'd4, 0, 0, 0);
        drive(3'd2, 32'h7FFF_FFFF, 6'd8, 0, 0, 0);
        drive(3'd2, 32'h8000_0001, 6'd31, 0, 0, 0);
        // R4
        drive(3'd2, 32'h8000_0000, 6'd32, 0, 0, 0);
        drive(3'd2, 32'h8000_0004, 6'd63, 0, 0, 0);
        drive(3'd2, 32'h7FFF_FFFF, 6'd32, 0, 0, 0);
        // R5
        drive(3'd2, 32'h8765_4321, 6'd0, 0, 0, 0);
        drive(3'd3, 32'hF000_000F, 6'd0, 0, 0, 0);
        // R6: amt bit 5 ignored
        drive(3'd3, 32'hFFFF_FF0F, 6'h24, 0, 0, 0);
        drive(3'd3, 32'h8000_0000, 6'h20, 0, 0, 0);
        // R7/R8
        drive(3'd4, 32'h1234_5678, 6'd0, 5'd0, 5'd31, 0);
        drive(3'd4, 32'h1234_5678, 6'd8, 5'd8, 5'd15, 0);
        drive(3'd4, 32'hDEAD_BEEF, 6'd3, 5'd28, 5'd3, 0);
        drive(3'd4, 32'hFFFF_FFFF, 6'd0, 5'd7, 5'd7, 0);
        // R9
        drive(3'd5, 32'h0000_00AB, 6'd16, 5'd8, 5'd15, 32'hCAFE_F00D);
        drive(3'd5, 32'hFFFF_FFFF, 6'd1, 5'd30, 5'd1, 32'h0000_0000);
        // R10: unused codes
        drive(3'd6, 32'hFFFF_FFFF, 6'd1, 0, 0, 0);
        drive(3'd7, 32'hFFFF_FFFF, 6'd1, 0, 0, 0);
        // random sweep
        for (int i = 0; i < 300; i++) begin
            drive(3'($urandom_range(0, 5)), $urandom, 6'($urandom), 5'($urandom),
                  5'($urandom), $urandom);
        end
        @(negedge clk);
        in_valid = 0;
        repeat (3) @(negedge clk);
        // R11: nothing left outstanding, out_valid drops after idle
        check("R11", "scoreboard empty", sb.size(), 32'd0);
        check("R11", "idle out_valid", {31'd0, out_valid}, 32'd0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule